// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit turns a segment:offset logical address into a linear address, one request per clock. It has two translation modes. In real mode, the segment value is moved up by one hex digit to form a base. The offset is added to that base, and the sum is kept to 20 bits, so every result falls inside the lowest megabyte. In protected mode, the low bits of the segment value pick one entry of a small on-chip table of 24-bit bases, and the offset is added to the chosen base.

The current mode is held in a register, which a dedicated strobe loads; after reset the unit is in real mode. Table entries are loaded through a synchronous write port. Each request is answered one cycle later on a registered address output, and a valid flag marks that output.

Top module: `seg_xlat_unit`

## Requirements
- R1: In real mode the result is ({segment, 4'h0} + offset) taken modulo 2^20, with output bits 23:20 zero; 2222h:3333h gives 025553h and 1200h:F445h gives 021445h.
- R2: In real mode a carry out of bit 19 is dropped, so FFFFh:0010h gives 000000h and FFFFh:FFFFh gives 00FFEFh.
- R3: In protected mode the result is table[segment[3:0]] + zero-extended offset; segment bits 15:4 have no effect on the result.
- R4: In protected mode the 24-bit sum wraps modulo 2^24, so base FFFF00h with offset 0200h gives 000100h.
- R5: When tbl_we is high at a rising edge, tbl_data is stored in entry tbl_idx, and a lookup in any later cycle returns that value.
- R6: A protected-mode request in the same cycle as a write to the entry it selects uses the base held before that write.
- R7: When mode_we is high at a rising edge, the mode register takes mode_prot (1 = protected, 0 = real); a request in that same cycle is translated in the previous mode.
- R8: After reset lin_valid is 0, lin_addr is 0, the mode is real, and every table entry holds 0.
- R9: lin_valid and lin_addr update at the rising edge after a cycle with req_valid high; lin_valid is 0 after a cycle without a request, and lin_addr then keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Loads the mode register |
| mode_prot | input | 1 | New mode: 1 protected, 0 real |
| req_valid | input | 1 | Translation request strobe |
| seg_in | input | 16 | Segment value |
| off_in | input | 16 | Offset |
| tbl_we | input | 1 | Table write enable |
| tbl_idx | input | 4 | Table entry to write |
| tbl_data | input | 24 | Base value to write |
| lin_addr | output | 24 | Registered linear address |
| lin_valid | output | 1 | Result valid, one cycle after a request |

## Verification
A translation request can land in the same cycle as either of the two state-update ports: a table write or a mode change. The bench provokes the first case with a protected-mode request that selects entry 2 while a new base is written into entry 2. It expects the old base on the output, and it expects the new base on the request that follows. It provokes the second case with a request that coincides with a switch from protected to real mode. That result must still follow the protected-mode rule, and an identical request one cycle later must follow the real-mode rule.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;
  localparam int SEG_W  = 16;
  localparam int OFF_W  = 16;
  localparam int LIN_W  = 24;
  localparam int REAL_W = 20;
  localparam int SHIFT  = 4;
  localparam int TBL_N  = 16;
  localparam int IDX_W  = $clog2(TBL_N);

  typedef enum logic {
    MODE_REAL = 1'b0,
    MODE_PROT = 1'b1
  } xlat_mode_e;
endpackage

// File: rtl/seg_base_table.sv
module seg_base_table
  import seg_xlat_pkg::*;
#(
  parameter int DEPTH  = TBL_N,
  parameter int DATA_W = LIN_W,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] entry_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic              hit;
    logic [DATA_W-1:0] entry_d;

    always_comb begin
      hit     = wr_en && (wr_idx == AW'(g));
      entry_d = hit ? wr_data : entry_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) entry_q[g] <= '0;
      else        entry_q[g] <= entry_d;
    end
  end

  // Read from the stored state: a write in this cycle is not yet visible
  assign rd_data = entry_q[rd_idx];

  AST_TBL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (entry_q[$past(wr_idx)] == $past(wr_data))); // R5
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_xlat_pkg::*;
#(
  parameter int SW = SEG_W,
  parameter int OW = OFF_W,
  parameter int LW = LIN_W,
  parameter int RW = REAL_W,
  parameter int SH = SHIFT
) (
  input  xlat_mode_e    mode,
  input  logic [SW-1:0] seg,
  input  logic [OW-1:0] off,
  input  logic [LW-1:0] base,
  output logic [LW-1:0] lin
);
  logic [RW-1:0] real_base;
  logic [RW-1:0] real_sum;
  logic [LW-1:0] prot_sum;

  always_comb begin
    real_base = RW'({seg, {SH{1'b0}}});
    real_sum  = real_base + RW'(off);   // carry past bit RW-1 dropped
    prot_sum  = base + LW'(off);        // wraps at 2^LW
    lin       = (mode == MODE_PROT) ? prot_sum : LW'(real_sum);
  end
endmodule

// File: rtl/seg_xlat_unit.sv
module seg_xlat_unit
  import seg_xlat_pkg::*;
#(
  parameter int SW = SEG_W,
  parameter int OW = OFF_W,
  parameter int LW = LIN_W,
  parameter int RW = REAL_W,
  parameter int NE = TBL_N,
  localparam int AW = $clog2(NE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_we,
  input  logic          mode_prot,
  input  logic          req_valid,
  input  logic [SW-1:0] seg_in,
  input  logic [OW-1:0] off_in,
  input  logic          tbl_we,
  input  logic [AW-1:0] tbl_idx,
  input  logic [LW-1:0] tbl_data,
  output logic [LW-1:0] lin_addr,
  output logic          lin_valid
);
  xlat_mode_e    mode_q, mode_d;
  logic [LW-1:0] tbl_base;
  logic [LW-1:0] gen_lin;
  logic [LW-1:0] addr_q, addr_d;
  logic          vld_q, vld_d;

  // Mode register
  always_comb begin
    mode_d = mode_q;
    if (mode_we) mode_d = mode_prot ? MODE_PROT : MODE_REAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_REAL;
    else        mode_q <= mode_d;
  end

  seg_base_table #(.DEPTH(NE), .DATA_W(LW)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_we),
    .wr_idx  (tbl_idx),
    .wr_data (tbl_data),
    .rd_idx  (seg_in[AW-1:0]),
    .rd_data (tbl_base)
  );

  seg_addr_gen #(.SW(SW), .OW(OW), .LW(LW), .RW(RW), .SH(SHIFT)) u_gen (
    .mode (mode_q),
    .seg  (seg_in),
    .off  (off_in),
    .base (tbl_base),
    .lin  (gen_lin)
  );

  // Output register with request as clock enable
  always_comb begin
    vld_d  = req_valid;
    addr_d = req_valid ? gen_lin : addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      vld_q  <= vld_d;
    end
  end

  assign lin_addr  = addr_q;
  assign lin_valid = vld_q;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> lin_valid); // R9
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !lin_valid); // R9
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(lin_addr)); // R9
  AST_REAL_IN_1MB: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_q == MODE_REAL) |=> (lin_addr[LW-1:RW] == '0)); // R1
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> (logic'(mode_q) == $past(mode_prot))); // R7
endmodule

// File: tb/tb_seg_xlat_unit.sv
`timescale 1ns/1ps
module tb_seg_xlat_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_we, mode_prot, req_valid, tbl_we;
  logic [15:0] seg_in, off_in;
  logic [3:0]  tbl_idx;
  logic [23:0] tbl_data;
  logic [23:0] lin_addr;
  logic        lin_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  seg_xlat_unit dut (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_prot(mode_prot),
    .req_valid(req_valid), .seg_in(seg_in), .off_in(off_in),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_data(tbl_data),
    .lin_addr(lin_addr), .lin_valid(lin_valid)
  );

  // {protected, segment, offset, expected}
  localparam int NV = 9;
  localparam logic [56:0] VEC [NV] = '{
    {1'b0, 16'h2222, 16'h3333, 24'h025553},  // R1
    {1'b0, 16'h1200, 16'hF445, 24'h021445},  // R1
    {1'b0, 16'hFFFF, 16'h0010, 24'h000000},  // R2
    {1'b0, 16'hFFFF, 16'hFFFF, 24'h00FFEF},  // R2
    {1'b0, 16'h0000, 16'h0000, 24'h000000},  // R1
    {1'b1, 16'h0003, 16'h1234, 24'h302234},  // R3
    {1'b1, 16'hABC3, 16'h1234, 24'h302234},  // R3 upper bits ignored
    {1'b1, 16'h000F, 16'hFFFF, 24'hF10FFF},  // R3
    {1'b1, 16'h0000, 16'h0005, 24'h001005}   // R3
  };

  function automatic logic [23:0] base_of(int i);
    return (24'(i) << 20) | 24'h001000;
  endfunction

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %06h expected %06h", req, act, exp);
    end
  endtask

  task automatic cyc(logic rq, logic [15:0] s, logic [15:0] o,
                     logic we, logic [3:0] ix, logic [23:0] d,
                     logic mwe, logic mp);
    @(negedge clk);
    req_valid = rq; seg_in = s; off_in = o;
    tbl_we = we; tbl_idx = ix; tbl_data = d;
    mode_we = mwe; mode_prot = mp;
    @(posedge clk);
    #1;
  endtask

  initial begin
    for (int t = 0; t < 20000; t++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic cur_prot;
    rst_n = 1'b0;
    mode_we = 0; mode_prot = 0; req_valid = 0; tbl_we = 0;
    seg_in = '0; off_in = '0; tbl_idx = '0; tbl_data = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R8 valid after reset", 24'(lin_valid), 24'h0);
    check("R8 addr after reset", lin_addr, 24'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // Reset mode is real
    cyc(1, 16'h0001, 16'h0000, 0, 0, 0, 0, 0);
    check("R8 real mode after reset", lin_addr, 24'h000010);
    check("R9 valid after request", 24'(lin_valid), 24'h1);

    // Table entries are zero after reset
    cyc(0, 0, 0, 0, 0, 0, 1, 1);
    cyc(1, 16'h0005, 16'h0007, 0, 0, 0, 0, 0);
    check("R8 table zero after reset", lin_addr, 24'h000007);
    cur_prot = 1'b1;

    for (int i = 0; i < 16; i++)
      cyc(0, 0, 0, 1, 4'(i), base_of(i), 0, 0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][56] != cur_prot) begin
        cyc(0, 0, 0, 0, 0, 0, 1, VEC[v][56]);
        cur_prot = VEC[v][56];
      end
      cyc(1, VEC[v][55:40], VEC[v][39:24], 0, 0, 0, 0, 0);
      check(VEC[v][56] ? "R3 protected vector" : "R1/R2 real vector",
            lin_addr, VEC[v][23:0]);
    end

    // R6: lookup and write to the same entry together
    cyc(1, 16'h0002, 16'h0000, 1, 4'd2, 24'h222222, 0, 0);
    check("R6 same-cycle write gives old base", lin_addr, 24'h201000);
    cyc(1, 16'h0002, 16'h0000, 0, 0, 0, 0, 0);
    check("R5 new base visible", lin_addr, 24'h222222);

    // R9: idle cycle
    cyc(0, 16'h0007, 16'h1111, 0, 0, 0, 0, 0);
    check("R9 valid low when idle", 24'(lin_valid), 24'h0);
    check("R9 addr held when idle", lin_addr, 24'h222222);

    // R4: wrap in protected mode
    cyc(0, 0, 0, 1, 4'd9, 24'hFFFF00, 0, 0);
    cyc(1, 16'h0009, 16'h0200, 0, 0, 0, 0, 0);
    check("R4 protected wrap", lin_addr, 24'h000100);

    // R7: mode change with a request in the same cycle
    cyc(1, 16'h0003, 16'h0001, 0, 0, 0, 1, 0);
    check("R7 request uses old mode", lin_addr, 24'h301001);
    cyc(1, 16'h0003, 16'h0001, 0, 0, 0, 0, 0);
    check("R7 new mode applied", lin_addr, 24'h000031);
    check("R9 valid on back-to-back", 24'(lin_valid), 24'h1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule